// File: doc/BRIEF.md
# DMA Descriptor Integrity Checker

This block inspects a sixteen-word, 32-bit DMA descriptor while it arrives one word per accepted cycle, and issues one verdict per descriptor. A verdict says whether the descriptor may be executed and, if not, which check rejected it. The checks are a fixed marker byte in the control word, an optional additive checksum carried in the final word, and a completion marker that flags a descriptor that was already processed.

The verdict also carries the decoded control flags, a derived per-channel status word, and the line size and line stride in bytes. A channel engine places this checker between its descriptor fetch path and its transfer sequencer. It feeds the checker the fetched words with a start marker on word 0, and acts on the verdict. A start marker that arrives before sixteen words have been seen means the previous fetch was cut short.

Top module: `desc_vet`

## Requirements
- R1: Each valid word that carries `wd_first` is word 0 of a new descriptor. The following valid words take indices 1 to 15. A valid word without `wd_first` while no descriptor is open is ignored and produces no verdict. Word 0 is the control word, word 3 is the line word, word 5 is the timestamp-high word and word 15 is the checksum word.
- R2: `vd_valid` is high for exactly one cycle, in the cycle after word 15 is accepted (or after an aborting start, see R7), and is low at all other times, including after reset.
- R3: If control bits 7:0 differ from 0xA5, the verdict code is 1 (marker error).
- R4: If control bit 20 is set and the 32-bit wrapping sum of words 0 to 14 differs from word 15, the verdict code is 2 (checksum error). When control bit 20 is clear, word 15 has no effect.
- R5: If bit 31 of word 5 is set and control bit 10 is clear, the verdict code is 3 (already-done error). When control bit 10 is set, the marker has no effect on the code.
- R6: Only the first failing check is reported, in the order marker, then checksum, then already-done. Code 0 means the descriptor passed every check.
- R7: A `wd_first` word that arrives while 1 to 15 words of a descriptor are open yields code 4 (fetch error) in the next cycle, with flags, status and line outputs all zero. The new descriptor that this word starts is checked normally.
- R8: A start marker restarts the running sum, so words of an aborted descriptor do not enter the next checksum.
- R9: `vd_flags` bit 0 = control bit 8 (done interrupt), 1 = bit 9 (write-back), 2 = bit 10 (ignore done), 3 = bit 11 (burst type), 4 = bit 18 (fragmented mode, 0 means contiguous), 5 = bit 19 (last descriptor), 6 = bit 20 (checksum enable), 7 = bit 21 (last of frame).
- R10: `vd_status` holds control bits 7:0 in bits 20:13. Its other bits are: bit 4 burst type, bit 5 mode, bit 6 checksum enable, bit 7 last, bit 8 last of frame, bit 9 ignore done, bit 10 the done marker of word 5, bit 11 write-back enable, bit 12 interrupt enable. All remaining bits are zero.
- R11: `vd_line_bytes` is bits 17:0 of word 3. `vd_stride_bytes` is bits 31:18 of word 3 multiplied by 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wd_valid | input | 1 | Word present this cycle |
| wd_first | input | 1 | Word is word 0 of a descriptor |
| wd_data | input | 32 | Descriptor word |
| vd_valid | output | 1 | Verdict pulse |
| vd_err | output | 3 | Verdict code: 0 ok, 1 marker, 2 checksum, 3 already done, 4 fetch |
| vd_flags | output | 8 | Decoded control flags |
| vd_status | output | 32 | Derived status word |
| vd_line_bytes | output | 18 | Line size in bytes |
| vd_stride_bytes | output | 18 | Line stride in bytes |

## Verification
Every verdict falls due in the cycle right after the edge that accepts word 15 or the aborting start word. The verdict is never combinational and never arrives later. The reference model runs on the same edge as the design, from the same inputs. It keeps the open descriptor in a queue and raises its expected pulse for that edge alone. The outputs are compared on the following falling edge. The compare runs on every cycle, so a pulse that is early, late, doubled or missing is caught. This covers idle gaps inside a descriptor and stray words outside one.

// File: rtl/desc_vet_pkg.sv
package desc_vet_pkg;

  typedef enum logic [2:0] {
    VERD_OK       = 3'd0,
    VERD_MARKER   = 3'd1,
    VERD_CHECKSUM = 3'd2,
    VERD_DONE     = 3'd3,
    VERD_FETCH    = 3'd4
  } verd_e;

  typedef struct packed {
    logic frame_end;
    logic sum_en;
    logic chain_end;
    logic frag_mode;
    logic burst_sel;
    logic skip_done;
    logic wb_en;
    logic irq_en;
  } ctl_flags_t;

  localparam logic [7:0] MARKER_BYTE = 8'hA5;

  localparam int unsigned CB_IRQ   = 8;
  localparam int unsigned CB_WB    = 9;
  localparam int unsigned CB_SKIP  = 10;
  localparam int unsigned CB_BURST = 11;
  localparam int unsigned CB_FRAG  = 18;
  localparam int unsigned CB_LAST  = 19;
  localparam int unsigned CB_SUM   = 20;
  localparam int unsigned CB_FRAME = 21;

  localparam int unsigned IDX_CTRL = 0;
  localparam int unsigned IDX_LINE = 3;
  localparam int unsigned IDX_TSHI = 5;
  localparam int unsigned DONE_BIT = 31;

endpackage

// File: rtl/desc_vet_seq.sv
module desc_vet_seq #(
  parameter int unsigned NWORDS = 16,
  localparam int unsigned IW = $clog2(NWORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wd_valid,
  input  logic          wd_first,
  output logic          acc,
  output logic [IW-1:0] idx,
  output logic          is_final,
  output logic          abort,
  output logic          busy
);

  logic          busy_q, busy_d;
  logic [IW-1:0] cnt_q, cnt_d;

  always_comb begin
    acc      = wd_valid && (wd_first || busy_q);
    idx      = wd_first ? '0 : cnt_q;
    abort    = wd_valid && wd_first && busy_q;
    is_final = acc && (idx == IW'(NWORDS - 1));
    busy_d   = busy_q;
    cnt_d    = cnt_q;
    if (acc) begin
      if (is_final) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        busy_d = 1'b1;
        cnt_d  = idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (acc) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;

  AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_valid && !wd_first && !busy_q) |=> !busy_q); // R1

endmodule

// File: rtl/desc_vet_sum.sv
module desc_vet_sum #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          first,
  input  logic          is_final,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] sum_q
);

  logic [DW-1:0] sum_d;
  logic          sum_en;

  always_comb begin
    sum_en = acc && !is_final;
    sum_d  = first ? data : (sum_q + data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (sum_en) begin
      sum_q <= sum_d;
    end
  end

  AST_SUM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && first) |=> (sum_q == $past(data))); // R8

endmodule

// File: rtl/desc_vet_capture.sv
module desc_vet_capture
  import desc_vet_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] line_q,
  output logic          done_q
);

  logic ctrl_en, line_en, done_en;

  always_comb begin
    ctrl_en = acc && (idx == IW'(IDX_CTRL));
    line_en = acc && (idx == IW'(IDX_LINE));
    done_en = acc && (idx == IW'(IDX_TSHI));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      line_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q <= data;
      if (line_en) line_q <= data;
      if (done_en) done_q <= data[DONE_BIT];
    end
  end

endmodule

// File: rtl/desc_vet_judge.sv
module desc_vet_judge
  import desc_vet_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned LSZ_W = 18,
  localparam int unsigned STR_W = DW - LSZ_W,
  localparam int unsigned SB_W = LSZ_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_final,
  input  logic             abort,
  input  logic [DW-1:0]    ctrl_q,
  input  logic [DW-1:0]    line_q,
  input  logic             done_q,
  input  logic [DW-1:0]    sum_q,
  input  logic [DW-1:0]    data,
  output logic             vd_valid,
  output verd_e            vd_err,
  output ctl_flags_t       vd_flags,
  output logic [DW-1:0]    vd_status,
  output logic [LSZ_W-1:0] vd_line_bytes,
  output logic [SB_W-1:0]  vd_stride_bytes
);

  verd_e            err_d;
  ctl_flags_t       flg_d;
  logic [DW-1:0]    sts_d;
  logic [LSZ_W-1:0] lsz_d;
  logic [SB_W-1:0]  str_d;
  logic             upd;

  always_comb begin
    upd = abort || is_final;
    flg_d.irq_en    = ctrl_q[CB_IRQ];
    flg_d.wb_en     = ctrl_q[CB_WB];
    flg_d.skip_done = ctrl_q[CB_SKIP];
    flg_d.burst_sel = ctrl_q[CB_BURST];
    flg_d.frag_mode = ctrl_q[CB_FRAG];
    flg_d.chain_end = ctrl_q[CB_LAST];
    flg_d.sum_en    = ctrl_q[CB_SUM];
    flg_d.frame_end = ctrl_q[CB_FRAME];

    sts_d        = '0;
    sts_d[20:13] = ctrl_q[7:0];
    sts_d[4]     = flg_d.burst_sel;
    sts_d[5]     = flg_d.frag_mode;
    sts_d[6]     = flg_d.sum_en;
    sts_d[7]     = flg_d.chain_end;
    sts_d[8]     = flg_d.frame_end;
    sts_d[9]     = flg_d.skip_done;
    sts_d[10]    = done_q;
    sts_d[11]    = flg_d.wb_en;
    sts_d[12]    = flg_d.irq_en;

    lsz_d = line_q[LSZ_W-1:0];
    str_d = SB_W'({line_q[DW-1:LSZ_W], 4'b0000});

    if (ctrl_q[7:0] != MARKER_BYTE)
      err_d = VERD_MARKER;
    else if (flg_d.sum_en && (sum_q != data))
      err_d = VERD_CHECKSUM;
    else if (done_q && !flg_d.skip_done)
      err_d = VERD_DONE;
    else
      err_d = VERD_OK;

    if (abort) begin
      err_d = VERD_FETCH;
      flg_d = '0;
      sts_d = '0;
      lsz_d = '0;
      str_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vd_valid <= 1'b0;
    end else begin
      vd_valid <= upd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vd_err          <= VERD_OK;
      vd_flags        <= '0;
      vd_status       <= '0;
      vd_line_bytes   <= '0;
      vd_stride_bytes <= '0;
    end else if (upd) begin
      vd_err          <= err_d;
      vd_flags        <= flg_d;
      vd_status       <= sts_d;
      vd_line_bytes   <= lsz_d;
      vd_stride_bytes <= str_d;
    end
  end

  AST_MARKER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_valid && vd_err != VERD_FETCH && vd_status[20:13] != MARKER_BYTE)
      |-> vd_err == VERD_MARKER); // R6

  AST_SKIP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_valid && vd_flags.skip_done) |-> vd_err != VERD_DONE); // R5

endmodule

// File: rtl/desc_vet.sv
module desc_vet
  import desc_vet_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned NWORDS = 16,
  parameter int unsigned LSZ_W = 18,
  localparam int unsigned IW = $clog2(NWORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wd_valid,
  input  logic             wd_first,
  input  logic [DW-1:0]    wd_data,
  output logic             vd_valid,
  output logic [2:0]       vd_err,
  output logic [7:0]       vd_flags,
  output logic [DW-1:0]    vd_status,
  output logic [LSZ_W-1:0] vd_line_bytes,
  output logic [LSZ_W-1:0] vd_stride_bytes
);

  logic          acc, is_final, abort, busy;
  logic [IW-1:0] idx;
  logic [DW-1:0] sum_q, ctrl_q, line_q;
  logic          done_q;
  verd_e         err_q;
  ctl_flags_t    flg_q;

  desc_vet_seq #(.NWORDS(NWORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .wd_valid(wd_valid), .wd_first(wd_first),
    .acc(acc), .idx(idx), .is_final(is_final), .abort(abort), .busy(busy)
  );

  desc_vet_sum #(.DW(DW)) u_sum (
    .clk(clk), .rst_n(rst_n), .acc(acc), .first(wd_first),
    .is_final(is_final), .data(wd_data), .sum_q(sum_q)
  );

  desc_vet_capture #(.DW(DW), .IW(IW)) u_cap (
    .clk(clk), .rst_n(rst_n), .acc(acc), .idx(idx), .data(wd_data),
    .ctrl_q(ctrl_q), .line_q(line_q), .done_q(done_q)
  );

  desc_vet_judge #(.DW(DW), .LSZ_W(LSZ_W)) u_judge (
    .clk(clk), .rst_n(rst_n), .is_final(is_final), .abort(abort),
    .ctrl_q(ctrl_q), .line_q(line_q), .done_q(done_q), .sum_q(sum_q),
    .data(wd_data), .vd_valid(vd_valid), .vd_err(err_q), .vd_flags(flg_q),
    .vd_status(vd_status), .vd_line_bytes(vd_line_bytes),
    .vd_stride_bytes(vd_stride_bytes)
  );

  assign vd_err   = err_q;
  assign vd_flags = flg_q;

  AST_VERDICT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_valid && !wd_first && busy && idx == IW'(NWORDS - 1))
      |=> (vd_valid && vd_err != 3'd4)); // R2

  AST_FETCH_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_valid && wd_first && busy) |=> (vd_valid && vd_err == 3'd4 && vd_status == '0)); // R7

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_valid) |=> !vd_valid); // R2

endmodule

// File: tb/tb_desc_vet.sv
module tb_desc_vet;

  logic        clk, rst_n;
  logic        wd_valid, wd_first;
  logic [31:0] wd_data;
  logic        vd_valid;
  logic [2:0]  vd_err;
  logic [7:0]  vd_flags;
  logic [31:0] vd_status;
  logic [17:0] vd_line_bytes, vd_stride_bytes;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  string tag = "R2";

  desc_vet dut (
    .clk(clk), .rst_n(rst_n), .wd_valid(wd_valid), .wd_first(wd_first),
    .wd_data(wd_data), .vd_valid(vd_valid), .vd_err(vd_err),
    .vd_flags(vd_flags), .vd_status(vd_status),
    .vd_line_bytes(vd_line_bytes), .vd_stride_bytes(vd_stride_bytes)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference: queue of open words, verdict expected for one cycle
  logic [31:0] q[$];
  logic        e_valid;
  logic [2:0]  e_err;
  logic [7:0]  e_flags;
  logic [31:0] e_status;
  logic [17:0] e_line, e_stride;

  task automatic model_verdict();
    logic [31:0] c, s;
    s = 32'd0;
    for (int i = 0; i < 15; i++) s = s + q[i];
    c = q[0];
    e_flags  = {c[21], c[20], c[19], c[18], c[11], c[10], c[9], c[8]};
    e_status = 32'd0;
    e_status[20:13] = c[7:0];
    e_status[4] = c[11]; e_status[5] = c[18]; e_status[6] = c[20];
    e_status[7] = c[19]; e_status[8] = c[21]; e_status[9] = c[10];
    e_status[10] = q[5][31]; e_status[11] = c[9]; e_status[12] = c[8];
    e_line   = q[3][17:0];
    e_stride = 18'(q[3][31:18]) * 18'd16;
    if (c[7:0] != 8'hA5) e_err = 3'd1;
    else if (c[20] && s != q[15]) e_err = 3'd2;
    else if (q[5][31] && !c[10]) e_err = 3'd3;
    else e_err = 3'd0;
  endtask

  always @(posedge clk) begin
    e_valid = 1'b0;
    if (!rst_n) begin
      q.delete();
    end else if (wd_valid) begin
      if (wd_first) begin
        if (q.size() > 0) begin
          e_valid = 1'b1; e_err = 3'd4; e_flags = '0; e_status = '0;
          e_line = '0; e_stride = '0;
        end
        q.delete();
        q.push_back(wd_data);
      end else if (q.size() > 0) begin
        q.push_back(wd_data);
        if (q.size() == 16) begin
          model_verdict();
          e_valid = 1'b1;
          q.delete();
        end
      end
    end
  end

  // compare every cycle, half a period after the edge
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      n_checks++;
      if (vd_valid !== e_valid) begin
        n_fail++;
        $display("FAIL %s/R2 vd_valid act=%0b exp=%0b", tag, vd_valid, e_valid);
      end
      if (e_valid && vd_valid) begin
        n_checks += 4;
        if (vd_err !== e_err) begin
          n_fail++;
          $display("FAIL %s verdict code act=%0d exp=%0d", tag, vd_err, e_err);
        end
        if (vd_flags !== e_flags) begin
          n_fail++;
          $display("FAIL R9 flags act=%h exp=%h", vd_flags, e_flags);
        end
        if (vd_status !== e_status) begin
          n_fail++;
          $display("FAIL R10 status act=%h exp=%h", vd_status, e_status);
        end
        if (vd_line_bytes !== e_line || vd_stride_bytes !== e_stride) begin
          n_fail++;
          $display("FAIL R11 line/stride act=%0d/%0d exp=%0d/%0d",
                   vd_line_bytes, vd_stride_bytes, e_line, e_stride);
        end
      end
    end
  end

  logic [31:0] d [16];

  // sum_mode: 0 arbitrary word 15, 1 correct sum, 2 sum plus one
  task automatic build(input logic [31:0] ctrl, input logic done, input int sum_mode);
    logic [31:0] s;
    d[0] = ctrl;
    for (int i = 1; i < 16; i++) d[i] = $urandom;
    d[2] = 32'hFFFF_FFF0;
    d[5][31] = done;
    s = 32'd0;
    for (int i = 0; i < 15; i++) s = s + d[i];
    if (sum_mode == 1) d[15] = s;
    else if (sum_mode == 2) d[15] = s + 32'd1;
  endtask

  task automatic put(input logic f, input logic [31:0] v);
    @(negedge clk);
    wd_valid = 1'b1; wd_first = f; wd_data = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wd_valid = 1'b0; wd_first = 1'b0; wd_data = $urandom;
    end
  endtask

  task automatic send(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      put(i == 0, d[i]);
      if (gap != 0 && (i % 3) == 1) idle(gap);
    end
  endtask

  localparam logic [31:0] C_OK = 32'h0000_00A5;

  initial begin
    wd_valid = 1'b0; wd_first = 1'b0; wd_data = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R2: reset state
    n_checks++;
    if (vd_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R2 reset vd_valid act=%0b exp=0", vd_valid);
    end
    rst_n = 1'b1;
    idle(2);

    tag = "R1";  // stray words with no open descriptor
    for (int i = 0; i < 5; i++) put(1'b0, 32'h0000_00A5);
    idle(3);
    tag = "R1";  build(C_OK | 32'h002B_0B00, 1'b0, 0); send(16, 0); idle(3);
    tag = "R11"; build(C_OK | 32'h0004_0300, 1'b0, 0); d[3] = 32'hFFFF_FFFF; send(16, 1); idle(2);
    tag = "R4";  build(C_OK | 32'h0010_0000, 1'b0, 1); send(16, 0); idle(2);
    tag = "R4";  build(C_OK | 32'h0010_0000, 1'b0, 2); send(16, 2); idle(2);
    tag = "R4";  build(C_OK, 1'b0, 2); send(16, 0); idle(2);
    tag = "R3";  build(32'h0000_00A4, 1'b0, 0); send(16, 0); idle(2);
    tag = "R6";  build(32'h0010_005A, 1'b1, 2); send(16, 0); idle(2);
    tag = "R6";  build(C_OK | 32'h0010_0000, 1'b1, 2); send(16, 0); idle(2);
    tag = "R5";  build(C_OK, 1'b1, 0); send(16, 0); idle(2);
    tag = "R5";  build(C_OK | 32'h0000_0400, 1'b1, 0); send(16, 0); idle(2);
    tag = "R7";  build(32'hDEAD_BEEF, 1'b0, 0); send(7, 0);
    tag = "R8";  build(C_OK | 32'h0010_0000, 1'b0, 1); send(16, 0); idle(2);
    tag = "R7";  build(C_OK, 1'b0, 0); send(15, 0);
    build(C_OK | 32'h0010_0000, 1'b0, 1); send(16, 0);
    tag = "R2";  build(C_OK | 32'h0030_0100, 1'b0, 1); send(16, 0);
    build(C_OK, 1'b1, 0); send(16, 0); idle(3);
    for (int k = 0; k < 20; k++) begin
      tag = "R6";
      build({$urandom} & 32'h003F_0FFF | ((k % 3 == 0) ? 32'h0 : C_OK),
            1'($urandom), k % 3);
      send(16, k % 2);
    end
    idle(4);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule